// File: doc/BRIEF.md
# Vector Lane Rounding Shifter

This block applies a rounding shift to every lane of a 128-bit vector. Each lane of `src_a` is shifted by a signed count taken from the matching lane of `src_b`. A positive count shifts left. A negative count shifts right and rounds to the nearest value by adding half of the last kept bit before the shift. The lane width (8, 16 or 32 bits) and whether lanes are signed or unsigned are chosen for each operation.

Counts that fall outside the element follow fixed boundary rules rather than wrapping. The merged result is registered once. A per-byte enable chooses, for each byte, between the computed value and the previous destination value supplied on `dest_prev`. This lets a predicated vector operation write only the bytes it owns.

Control is a two-state machine, ST_IDLE and ST_RESULT, that produces `out_valid`:
- ST_IDLE goes to ST_RESULT when `in_valid` is high, and stays in ST_IDLE otherwise.
- ST_RESULT stays in ST_RESULT when `in_valid` is high, and returns to ST_IDLE otherwise.
- Reset forces ST_IDLE.

Top module: `vec_rshift_top`

## Requirements
- R1: `size_sel` picks the lane layout, with lane 0 in the least significant bits. 2'b00 gives sixteen 8-bit lanes, 2'b01 gives eight 16-bit lanes, and 2'b10 or 2'b11 gives four 32-bit lanes.
- R2: A lane's shift count k is bits [7:0] of the matching `src_b` lane, read as a two's-complement 8-bit value. All higher bits of that lane are ignored.
- R3: When 0 <= k < W (W is the lane width), the lane result is the lane shifted left by k. Bits that move past bit W-1 are dropped and there is no saturation.
- R4: When k >= W, the lane result is zero.
- R5: When -W < k < 0, the lane result is (x + 2^(-k-1)) shifted right by -k and truncated to W bits. The sum is formed in W+1 bits so the rounding carry is kept. Signed lanes (`is_signed`=1) sign-extend x and shift arithmetically. Unsigned lanes zero-extend x and shift logically.
- R6: In an unsigned lane, k = -W gives the lane's top bit as the result (the value 0 or 1), and k < -W gives zero.
- R7: In a signed lane, any k <= -W gives zero.
- R8: Each output byte i takes the computed byte when `byte_en[i]` is 1 and takes `dest_prev` byte i when `byte_en[i]` is 0.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` changes only on a clock edge where `in_valid` is high, and otherwise holds its value.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| src_a | input | 128 | Vector of values to shift |
| src_b | input | 128 | Vector holding the per-lane shift counts |
| dest_prev | input | 128 | Previous destination, kept in disabled bytes |
| size_sel | input | 2 | Lane width code |
| is_signed | input | 1 | 1 selects signed lanes, 0 selects unsigned lanes |
| byte_en | input | 16 | Per-byte write enable |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 128 | Registered result |

## Verification
Directed vectors place a hand-worked value in each lane:
- Counts of exactly W and -W, W-1, and one step beyond -W, which separate the unsigned top-bit rule from the signed zero rule.
- All-ones and most-negative values shifted right by one, which show whether the rounding carry survives the widened add.
- Word lanes whose `src_b` upper bytes are nonzero, which show that only the low byte is used as the count.

Random operations then cover every size code, both signednesses, counts clustered around the lane boundaries, sparse byte enables and idle gaps. The bench compares the registered output against a behavioural model on every clock, so the hold behaviour, the valid timing and a mid-stream reset are all checked.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } elem_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    localparam int NUM_SIZES = 3;
endpackage

// File: rtl/vrs_lane_unit.sv
module vrs_lane_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] lane_a,
    input  logic [W-1:0] lane_b,
    input  logic         sgn,
    output logic [W-1:0] lane_y
);
    localparam int AW = $clog2(W) + 1;

    logic signed [7:0] k;
    logic [AW-1:0]     amt;
    logic [W:0]        ext;
    logic [W:0]        rnd;
    logic [W:0]        sum;
    logic [W:0]        shr;
    int                nsh;

    assign k = lane_b[7:0];

    generate
        if (W > 8) begin : g_hi
            logic unused_b_hi;
            assign unused_b_hi = ^lane_b[W-1:8];
        end
    endgenerate

    always_comb begin
        lane_y = '0;
        nsh    = -int'(k);
        amt    = '0;
        ext    = {sgn & lane_a[W-1], lane_a};
        rnd    = '0;
        sum    = '0;
        shr    = '0;
        if (k >= 0) begin
            if (k < W) begin
                lane_y = lane_a << k[AW-1:0];
            end
        end else if ((nsh < W) || ((nsh == W) && !sgn)) begin
            amt = AW'(nsh);
            rnd = (W+1)'(1) << (amt - AW'(1));
            sum = ext + rnd;
            if (sgn) begin
                shr = $unsigned($signed(sum) >>> amt);
            end else begin
                shr = sum >> amt;
            end
            lane_y = shr[W-1:0];
        end
    end
endmodule

// File: rtl/vrs_lane_array.sv
module vrs_lane_array #(
    parameter int VEC_W = 128,
    parameter int W     = 8
) (
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic             sgn,
    output logic [VEC_W-1:0] vec_y
);
    localparam int NUM_LANES = VEC_W / W;

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            vrs_lane_unit #(.W(W)) u_lane (
                .lane_a (vec_a[i*W +: W]),
                .lane_b (vec_b[i*W +: W]),
                .sgn    (sgn),
                .lane_y (vec_y[i*W +: W])
            );
        end
    endgenerate
endmodule

// File: rtl/vrs_byte_merge.sv
module vrs_byte_merge #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]   computed,
    input  logic [VEC_W-1:0]   prior,
    input  logic [VEC_W/8-1:0] en,
    output logic [VEC_W-1:0]   merged
);
    localparam int NUM_BYTES = VEC_W / 8;

    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            assign merged[i*8 +: 8] = en[i] ? computed[i*8 +: 8] : prior[i*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/vec_rshift_top.sv
module vec_rshift_top
    import vrs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   dest_prev,
    input  logic [1:0]         size_sel,
    input  logic               is_signed,
    input  logic [VEC_W/8-1:0] byte_en,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data
);
    localparam int NUM_BYTES = VEC_W / 8;

    out_state_e       state_q;
    out_state_e       state_d;
    logic [VEC_W-1:0] by_size [NUM_SIZES];
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] merged;

    generate
        for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
            vrs_lane_array #(.VEC_W(VEC_W), .W(8 << g)) u_arr (
                .vec_a (src_a),
                .vec_b (src_b),
                .sgn   (is_signed),
                .vec_y (by_size[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (elem_size_e'(size_sel))
            SZ_BYTE:     lane_res = by_size[0];
            SZ_HALF:     lane_res = by_size[1];
            SZ_WORD:     lane_res = by_size[2];
            SZ_WORD_ALT: lane_res = by_size[2];
            default:     lane_res = by_size[2];
        endcase
    end

    vrs_byte_merge #(.VEC_W(VEC_W)) u_merge (
        .computed (lane_res),
        .prior    (dest_prev),
        .en       (byte_en[NUM_BYTES-1:0]),
        .merged   (merged)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
        end else if (in_valid) begin
            out_data <= merged;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_RESULT);
    end
endmodule

// File: rtl/vrs_checker.sv
module vrs_checker #(
    parameter int VEC_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [VEC_W-1:0]   src_a,
    input logic [VEC_W-1:0]   src_b,
    input logic [VEC_W-1:0]   dest_prev,
    input logic [VEC_W/8-1:0] byte_en,
    input logic               out_valid,
    input logic [VEC_W-1:0]   out_data
);
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    p_masked_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && byte_en == '0) |=> (out_data == $past(dest_prev)));

    p_zero_count_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_b == '0 && (&byte_en)) |=> (out_data == $past(src_a)));

    p_zero_value_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_a == '0 && (&byte_en)) |=> (out_data == '0));
endmodule

bind vec_rshift_top vrs_checker #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .dest_prev (dest_prev),
    .byte_en   (byte_en),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/vec_rshift_top_tb.sv
`timescale 1ns/1ps
module vec_rshift_top_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dest_prev = '0;
    logic [1:0]   size_sel = '0;
    logic         is_signed = 1'b0;
    logic [15:0]  byte_en = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int     n_checks = 0;
    int     n_errors = 0;
    int     cycles = 0;
    bit     running = 1'b0;
    string  cur_req = "R9";

    logic         m_v;
    logic [127:0] m_d;

    always #10 clk = ~clk;

    vec_rshift_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .dest_prev(dest_prev), .size_sel(size_sel), .is_signed(is_signed),
        .byte_en(byte_en), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint lane_ref(longint a, int k, int w, bit sgn);
        longint mask = (longint'(1) << w) - 1;
        longint r;
        if (k >= w) return 0;
        if (k >= 0) return (a << k) & mask;
        if (sgn) begin
            if (k <= -w) return 0;
            if (a[w-1]) a = a - (longint'(1) << w);
            r = (a + (longint'(1) << (-k - 1))) >>> (-k);
        end else begin
            if (k < -w) return 0;
            r = (a + (longint'(1) << (-k - 1))) >> (-k);
        end
        return r & mask;
    endfunction

    function automatic logic [127:0] vec_ref(logic [127:0] va, logic [127:0] vb,
                                             logic [127:0] vd, logic [1:0] sz,
                                             bit sgn, logic [15:0] en);
        int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        logic [127:0] res = '0;
        for (int l = 0; l < 128 / w; l++) begin
            logic [127:0] ta = va >> (l * w);
            logic [127:0] tb = vb >> (l * w);
            logic signed [7:0] kb = tb[7:0];
            longint av = longint'(ta[31:0]) & ((longint'(1) << w) - 1);
            longint r = lane_ref(av, int'(kb), w, sgn);
            res = res | (128'(r) << (l * w));
        end
        for (int i = 0; i < 16; i++)
            if (!en[i]) res[i*8 +: 8] = vd[i*8 +: 8];
        return res;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_v <= 1'b0;
            m_d <= '0;
        end else begin
            m_v <= in_valid;
            if (in_valid) m_d <= vec_ref(src_a, src_b, dest_prev, size_sel, is_signed, byte_en);
        end
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            check("R9", 128'(out_valid), 128'(m_v));
            check(cur_req, out_data, m_d);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic op(logic [127:0] a, logic [127:0] b, logic [127:0] d,
                      logic [1:0] sz, bit sgn, logic [15:0] en);
        src_a = a; src_b = b; dest_prev = d; size_sel = sz; is_signed = sgn;
        byte_en = en; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(string req, logic [127:0] a, logic [127:0] b, logic [1:0] sz,
                            bit sgn, logic [127:0] exp);
        cur_req = req;
        op(a, b, {4{32'hA5C3_5A3C}}, sz, sgn, 16'hFFFF);
        check(req, out_data, exp);
        check(req, 128'(out_valid), 128'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", {127'(out_data), out_valid}, '0);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);

        // R6 R3 R4 unsigned bytes: FF@-8=01, 7F@-8=00, FF@-1=80 (R5 carry), FF@3=F8, 12@8=0, 12@-9=0
        directed("R6", {80'h0, 48'h1212_FFFF_7FFF}, {80'h0, 48'hF708_03FF_F8F8},
                 2'b00, 1'b0, {80'h0, 48'h0000_F880_0001});
        // R7 R5 signed bytes: 80@-7=FF, 7F@-1=40, 80@-8=00, 81@1=02
        directed("R7", {96'h0, 32'h8180_7F80}, {96'h0, 32'h01F8_FFF9},
                 2'b00, 1'b1, {96'h0, 32'h0200_40FF});
        // R2 R1 unsigned words, upper count bytes nonzero
        directed("R2", {32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF},
                 {32'hABCD_EF20, 32'h5555_551F, 32'h1234_56E0, 32'h0000_00FF},
                 2'b10, 1'b0, {32'h0, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000});
        // R5 signed halfwords: 8000@-15=FFFF, 0003@-1=0002, FFFD@-1=FFFF(-1.5 rounds to -1)
        directed("R5", {80'h0, 48'hFFFD_0003_8000}, {80'h0, 48'h00FF_00FF_00F1},
                 2'b01, 1'b1, {80'h0, 48'hFFFF_0002_FFFF});
        // R1 size code 11 acts as word
        directed("R1", {96'h0, 32'h0000_0100}, {96'h0, 32'h0000_00F8},
                 2'b11, 1'b0, {96'h0, 32'h0000_0001});
        // R8 half mask
        cur_req = "R8";
        op({4{32'h1111_2222}}, '0, {4{32'hDEAD_BEEF}}, 2'b00, 1'b0, 16'h00FF);
        check("R8", out_data, {{2{32'hDEAD_BEEF}}, {2{32'h1111_2222}}});
        // R9 hold during idle
        cur_req = "R9";
        repeat (3) @(negedge clk);
        check("R9", out_data, {{2{32'hDEAD_BEEF}}, {2{32'h1111_2222}}});

        // random sweep
        for (int n = 0; n < 600; n++) begin
            logic [127:0] a, b, d;
            logic [1:0] sz = 2'($urandom_range(0, 3));
            bit sgn = 1'($urandom);
            logic [15:0] en = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'hFFFF;
            for (int j = 0; j < 4; j++) begin
                a[j*32 +: 32] = $urandom;
                b[j*32 +: 32] = $urandom;
                d[j*32 +: 32] = $urandom;
            end
            for (int j = 0; j < 16; j++)
                if ($urandom_range(0, 4) != 0) b[j*8 +: 8] = 8'($urandom_range(0, 80) - 40);
            cur_req = sgn ? "R5" : "R3";
            if (n % 7 == 0) cur_req = "R4";
            op(a, b, d, sz, sgn, en);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        // R10 reset in the middle of traffic
        cur_req = "R10";
        src_a = {4{32'h7777_7777}}; byte_en = 16'hFFFF; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check("R10", {127'(out_data), out_valid}, '0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule